// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending Logic

This block gathers interrupt causes from two serial channels, called A and B, and presents them to a host processor. Each channel has three causes: an external/status change, a transmit buffer that has become empty, and a received character. The receive cause also carries a sticky receive error. Each cause is gated by that channel's own interrupt-mode register and then held in a pending latch. All pending latches are gathered into one shared status byte. A single active-high request line is raised when any latch is pending and the master enable in the shared master-control register is set.

The host reaches the registers through an indirect port, and each channel has two addresses: a control address and a data address. A control-address write while the channel's pointer is zero is a command byte. That byte loads the pointer and may carry a command code. The next control-address access reaches the register the pointer names, after which the pointer returns to zero. Pending latches are cleared by command codes, by a data-address write (transmit) or by a data-address read (received character). They are never cleared by reading the status byte.

Top module: `sio_irq_pending`

## Requirements
- R1: After reset every pending latch is clear, `irq` is low, and the mode registers of both channels and the master-control register read as zero.
- R2: Each channel has its own 4-bit pointer. A control write with pointer 0 loads pointer bits 2:0 from data bits 2:0 and pointer bit 3 from (data bits 5:3 == 1). The next control access on that channel reaches the selected register: 1 = interrupt mode (per channel, read/write), 3 = pending byte (read only), 9 = master control (shared). The pointer then returns to 0. A control read at pointer 0 returns that channel's own pending bits {rx, tx, ext} in bits 2:0.
- R3: The pending byte reads the same from either channel. Channel B is in bits 0 (external/status), 1 (transmit) and 2 (receive), channel A is in bits 3, 4 and 5 in the same order, and bits 7:6 read 0.
- R4: An `evt_ext` pulse sets the channel's external/status latch only when mode bit 0 is 1. Command code 2 (command byte bits 5:3) written on that channel clears it.
- R5: A rising edge of `tx_empty` sets the transmit latch only when mode bit 1 is 1. A steady high level does not set it again. Command code 5 or a data-address write on that channel clears it.
- R6: With mode bits 4:3 = 2 (every character), each `rx_char` pulse sets the receive latch. A data-address read on that channel clears it.
- R7: With mode bits 4:3 = 1 (first character), only the first `rx_char` after a write to the mode register sets the receive latch, and a rewrite of the register re-arms it. With mode bits 4:3 = 0, receive never sets.
- R8: An `rx_char` pulse with `rx_err` high, in any non-zero receive mode, sets a receive-error latch even when first-character mode is not armed. The error shows as the receive bit, survives a data read, and is cleared only by command code 6.
- R9: `irq` is high exactly when master-control bit 3 is 1 and any pending bit is set, with no register delay. Pending latches still collect causes while bit 3 is 0.
- R10: Writing master-control bits 7:6 = 1 resets channel B (mode, pending, pointer), 2 resets channel A, and 3 resets both channels and master control. Bits 5:0 of the same write are otherwise stored, and bits 7:6 always read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_chan | input | 1 | Channel select: 1 = A, 0 = B |
| bus_data_sel | input | 1 | 0 = control address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when idle or on data reads) |
| evt_ext | input | 2 | External/status change pulse, index 1 = A, 0 = B |
| tx_empty | input | 2 | Transmit buffer empty level |
| rx_char | input | 2 | Character received pulse |
| rx_err | input | 2 | Receive error qualifier, valid with rx_char |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest states to reach are those where a latch must stay clear after a cause, because the cause only counts once. One case is first-character mode after its single character has been taken. The other is a transmit-empty level that stays high after its latch has been cleared. The stimulus reaches the first by sending a character, draining it with a data read, and then sending another without touching the mode register. It then rewrites the register and checks that the next character sets the latch again. For the second, the stimulus holds `tx_empty` high across a clear command and reads the status byte back. It then drops and raises the line to show that a fresh edge sets the latch. The error latch is driven into the unarmed first-character state in the same way, so that a data read is seen to leave it pending.

// File: rtl/sio_irq_pending.sv
module sio_irq_pending #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_we,
  input  logic          bus_chan,
  input  logic          bus_data_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [1:0]    evt_ext,
  input  logic [1:0]    tx_empty,
  input  logic [1:0]    rx_char,
  input  logic [1:0]    rx_err,
  output logic          irq
);
  localparam logic [3:0] RegMode   = 4'd1;
  localparam logic [3:0] RegPend   = 4'd3;
  localparam logic [3:0] RegMaster = 4'd9;
  localparam logic [2:0] CmdHigh   = 3'd1;
  localparam logic [2:0] CmdClrExt = 3'd2;
  localparam logic [2:0] CmdClrTx  = 3'd5;
  localparam logic [2:0] CmdClrErr = 3'd6;
  localparam int MieBit = 3;

  logic [1:0][3:0]    ptr;
  logic [1:0][DW-1:0] mode;
  logic [5:0]         master;
  logic [1:0]         pend_ext, pend_tx, pend_rx, pend_err, armed, tx_q;

  wire ctl_acc = bus_cs & ~bus_data_sel;
  wire ctl_wr  = ctl_acc & bus_we;
  wire dat_wr  = bus_cs & bus_data_sel & bus_we;
  wire dat_rd  = bus_cs & bus_data_sel & ~bus_we;
  wire [3:0] cur_ptr = ptr[bus_chan];
  wire [2:0] cmd = bus_wdata[5:3];

  wire wr_cmd    = ctl_wr && cur_ptr == 4'd0;
  wire wr_mode   = ctl_wr && cur_ptr == RegMode;
  wire wr_master = ctl_wr && cur_ptr == RegMaster;
  wire [1:0] rst_req = wr_master ? bus_wdata[7:6] : 2'b00;
  wire rst_all = rst_req == 2'b11;
  wire [1:0] rst_ch = {rst_req[1], rst_req[0]};

  wire [2:0] bits_b = {pend_rx[0] | pend_err[0], pend_tx[0], pend_ext[0]};
  wire [2:0] bits_a = {pend_rx[1] | pend_err[1], pend_tx[1], pend_ext[1]};
  wire [7:0] pend_byte = {2'b00, bits_a, bits_b};

  assign irq = master[MieBit] & (|pend_byte);

  always_comb begin
    bus_rdata = '0;
    if (ctl_acc && !bus_we) begin
      case (cur_ptr)
        4'd0:      bus_rdata = DW'(bus_chan ? bits_a : bits_b);
        RegMode:   bus_rdata = mode[bus_chan];
        RegPend:   bus_rdata = DW'(pend_byte);
        RegMaster: bus_rdata = DW'(master);
        default:   bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0; mode <= '0; master <= '0;
      pend_ext <= '0; pend_tx <= '0; pend_rx <= '0; pend_err <= '0;
      armed <= '0; tx_q <= '0;
    end else begin
      if (rst_all) master <= '0;
      else if (wr_master) master <= bus_wdata[5:0];
      for (int c = 0; c < 2; c++) begin
        automatic logic own = (bus_chan == c[0]);
        automatic logic first_mode = mode[c][4:3] == 2'b01;
        tx_q[c] <= tx_empty[c];
        if (rst_ch[c]) begin
          ptr[c] <= '0; mode[c] <= '0; armed[c] <= 1'b0;
          pend_ext[c] <= 1'b0; pend_tx[c] <= 1'b0;
          pend_rx[c] <= 1'b0; pend_err[c] <= 1'b0;
        end else begin
          if (ctl_acc && own)
            ptr[c] <= wr_cmd ? {cmd == CmdHigh, bus_wdata[2:0]} : 4'd0;

          if (wr_mode && own) begin
            mode[c] <= bus_wdata; armed[c] <= 1'b1;
          end else if (rx_char[c] && first_mode) armed[c] <= 1'b0;

          if (evt_ext[c] && mode[c][0]) pend_ext[c] <= 1'b1;
          else if (own && wr_cmd && cmd == CmdClrExt) pend_ext[c] <= 1'b0;

          if (tx_empty[c] && !tx_q[c] && mode[c][1]) pend_tx[c] <= 1'b1;
          else if (own && ((wr_cmd && cmd == CmdClrTx) || dat_wr)) pend_tx[c] <= 1'b0;

          if (rx_char[c] && (mode[c][4] || (first_mode && armed[c]))) pend_rx[c] <= 1'b1;
          else if (own && dat_rd) pend_rx[c] <= 1'b0;

          if (rx_char[c] && rx_err[c] && mode[c][4:3] != 2'b00) pend_err[c] <= 1'b1;
          else if (own && wr_cmd && cmd == CmdClrErr) pend_err[c] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sio_irq_pending_chk.sv
module sio_irq_pending_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_cs,
  input logic       bus_we,
  input logic       bus_chan,
  input logic       bus_data_sel,
  input logic [7:0] bus_wdata,
  input logic [3:0] cur_ptr,
  input logic [1:0] evt_ext,
  input logic [1:0] tx_empty,
  input logic [1:0] rx_char,
  input logic [1:0] pend_ext,
  input logic [1:0] pend_tx,
  input logic [1:0] pend_rx,
  input logic [1:0] pend_err,
  input logic [1:0] armed,
  input logic [15:0] mode_flat,
  input logic [5:0] master,
  input logic       irq
);
  wire any_pend = |{pend_ext, pend_tx, pend_rx, pend_err};
  wire full_rst = bus_cs && bus_we && !bus_data_sel && cur_ptr == 4'd9 && bus_wdata[7:6] == 2'b11;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire [1:0] rxm = mode_flat[c*8+3 +: 2];
    wire rd_here = bus_cs && !bus_we && bus_data_sel && bus_chan == c[0];

    assert_ext_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_ext[c]) |-> $past(evt_ext[c]));

    assert_tx_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_tx[c]) |-> $past(tx_empty[c]));

    assert_data_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_here && !rx_char[c]) |=> !pend_rx[c]);

    assert_first_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_rx[c]) && $past(rxm) == 2'b01) |-> $past(armed[c]));
  end

  assert_full_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst |=> (!any_pend && master == 6'd0));

  assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> any_pend);
endmodule

bind sio_irq_pending sio_irq_pending_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_chan(bus_chan),
  .bus_data_sel(bus_data_sel), .bus_wdata(bus_wdata), .cur_ptr(cur_ptr),
  .evt_ext(evt_ext), .tx_empty(tx_empty), .rx_char(rx_char),
  .pend_ext(pend_ext), .pend_tx(pend_tx), .pend_rx(pend_rx), .pend_err(pend_err),
  .armed(armed), .mode_flat(mode), .master(master), .irq(irq)
);

// File: tb/sio_irq_pending_bench.sv
module sio_irq_pending_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 0, bus_we = 0, bus_chan = 0, bus_data_sel = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [1:0] evt_ext = 0, tx_empty = 0, rx_char = 0, rx_err = 0;
  logic irq;

  sio_irq_pending u_sio_irq_pending (.*);

  always #5 clk = ~clk;

  typedef struct { bit is_irq; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  bit mon_go = 0;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always @(negedge clk) if (mon_go) begin
    item_t it;
    if (sb.size() == 0) begin
      mismatched++; $display("FAIL scoreboard empty");
    end else begin
      logic [7:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {7'd0, irq} : bus_rdata;
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(bit cs, bit we, bit ch, bit ds, logic [7:0] wd, bit go = 0);
    @(posedge clk); #1;
    bus_cs = cs; bus_we = we; bus_chan = ch; bus_data_sel = ds; bus_wdata = wd; mon_go = go;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 8'h00); endtask

  function automatic logic [7:0] ptr_word(int r);
    return {2'b00, (r >= 8) ? 3'd1 : 3'd0, 3'(r)};
  endfunction

  task automatic wr_reg(bit ch, int r, logic [7:0] v);
    if (r != 0) cyc(1, 1, ch, 0, ptr_word(r));
    cyc(1, 1, ch, 0, v);
    idle();
  endtask

  task automatic chk_reg(bit ch, int r, logic [7:0] exp, string tag);
    if (r != 0) cyc(1, 1, ch, 0, ptr_word(r));
    sb.push_back('{0, exp, tag});
    cyc(1, 0, ch, 0, 8'h00, 1);
    idle();
  endtask

  task automatic chk_irq(bit exp, string tag);
    sb.push_back('{1, {7'd0, exp}, tag});
    cyc(0, 0, 0, 0, 8'h00, 1);
    idle();
  endtask

  task automatic strobe(logic [1:0] e, logic [1:0] r, logic [1:0] er);
    @(posedge clk); #1; evt_ext = e; rx_char = r; rx_err = er; mon_go = 0;
    @(posedge clk); #1; evt_ext = 0; rx_char = 0; rx_err = 0;
  endtask

  task automatic data_rd(bit ch); cyc(1, 0, ch, 1, 8'h00); idle(); endtask
  task automatic data_wr(bit ch); cyc(1, 1, ch, 1, 8'h5A); idle(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++; $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R1 reset state
    chk_reg(1, 3, 8'h00, "R1 pend");
    chk_reg(0, 1, 8'h00, "R1 modeB");
    chk_reg(1, 9, 8'h00, "R1 master");
    chk_irq(0, "R1 irq");
    // R2 indirect access
    wr_reg(0, 1, 8'h13);
    chk_reg(0, 1, 8'h13, "R2 modeB readback");
    chk_reg(1, 1, 8'h00, "R2 modeA separate");
    chk_reg(0, 0, 8'h00, "R2 pointer back to 0");
    // R4 external/status
    strobe(2'b01, 0, 0);
    chk_reg(0, 3, 8'h01, "R4 ext set");
    chk_irq(0, "R9 masked");
    strobe(2'b10, 0, 0);
    chk_reg(1, 3, 8'h01, "R4 disabled ext ignored");
    wr_reg(0, 0, 8'h10);
    chk_reg(0, 3, 8'h00, "R4 cmd2 clear");
    // R5 transmit
    @(posedge clk); #1 tx_empty[0] = 1;
    chk_reg(0, 3, 8'h02, "R5 tx edge");
    wr_reg(0, 0, 8'h28);
    chk_reg(0, 3, 8'h00, "R5 cmd5 clear");
    chk_reg(0, 3, 8'h00, "R5 level no reset");
    @(posedge clk); #1 tx_empty[0] = 0;
    @(posedge clk); #1 tx_empty[0] = 1;
    chk_reg(0, 3, 8'h02, "R5 new edge");
    data_wr(0);
    chk_reg(0, 3, 8'h00, "R5 data write clear");
    // R6 every character
    strobe(0, 2'b01, 0);
    chk_reg(0, 3, 8'h04, "R6 rx set");
    data_rd(0);
    chk_reg(0, 3, 8'h00, "R6 data read clear");
    strobe(0, 2'b01, 0);
    chk_reg(0, 3, 8'h04, "R6 rx again");
    data_rd(0);
    // R7 first character
    wr_reg(1, 1, 8'h08);
    strobe(0, 2'b10, 0);
    chk_reg(1, 3, 8'h20, "R7 first char");
    data_rd(1);
    strobe(0, 2'b10, 0);
    chk_reg(1, 3, 8'h00, "R7 second ignored");
    wr_reg(1, 1, 8'h08);
    strobe(0, 2'b10, 0);
    chk_reg(1, 3, 8'h20, "R7 re-armed");
    data_rd(1);
    wr_reg(1, 1, 8'h00);
    strobe(0, 2'b10, 0);
    chk_reg(1, 3, 8'h00, "R7 mode0 ignored");
    // R8 error
    wr_reg(1, 1, 8'h08);
    strobe(0, 2'b10, 2'b10);
    data_rd(1);
    chk_reg(1, 3, 8'h20, "R8 err survives read");
    wr_reg(1, 0, 8'h30);
    chk_reg(1, 3, 8'h00, "R8 cmd6 clear");
    strobe(0, 2'b10, 2'b10);
    chk_reg(1, 0, 8'h04, "R8 err unarmed");
    wr_reg(1, 0, 8'h30);
    chk_reg(1, 3, 8'h00, "R8 cleared again");
    // R9 master enable
    strobe(2'b01, 0, 0);
    chk_irq(0, "R9 mie off");
    wr_reg(0, 9, 8'h08);
    chk_irq(1, "R9 mie on");
    wr_reg(1, 9, 8'h00);
    chk_irq(0, "R9 mie off again");
    wr_reg(0, 9, 8'h08);
    wr_reg(0, 0, 8'h10);
    chk_irq(0, "R9 nothing pending");
    // R3 layout and R10 resets
    strobe(2'b01, 0, 0);
    wr_reg(1, 1, 8'h01);
    strobe(2'b10, 0, 0);
    chk_reg(1, 3, 8'h09, "R3 byte from A");
    chk_reg(0, 3, 8'h09, "R3 byte from B");
    chk_reg(1, 0, 8'h01, "R3 own bits A");
    wr_reg(1, 9, 8'h48);
    chk_reg(0, 3, 8'h08, "R10 reset B pend");
    chk_reg(0, 1, 8'h00, "R10 reset B mode");
    chk_reg(1, 1, 8'h01, "R10 A kept");
    chk_reg(0, 9, 8'h08, "R10 reset bits not stored");
    chk_irq(1, "R10 irq from A");
    wr_reg(0, 9, 8'h88);
    chk_reg(1, 3, 8'h00, "R10 reset A pend");
    chk_reg(1, 1, 8'h00, "R10 reset A mode");
    chk_irq(0, "R10 irq cleared");
    wr_reg(0, 9, 8'h2A);
    wr_reg(0, 9, 8'hC0);
    chk_reg(1, 9, 8'h00, "R10 full reset master");
    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin mismatched++; $display("FAIL scoreboard left %0d", sb.size()); end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule